// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits between a requester and a serial-flash command engine. The requester asks for one high-level operation: erase a 4 KB sector, erase a 32 KB or 64 KB block, erase the whole device, program a byte range, or rewrite the protection and quad-enable fields of the device status. The sequencer breaks that operation into the ordered list of single commands the device needs. The engine only moves one command at a time over the wires. The sequencer starts each command with a one-cycle start pulse and waits for the engine's completion pulse before it goes on.

Every modifying command is wrapped in the same frame. First the status byte is read until the busy bit is zero. Then write enable is sent, then the command itself, and then the status byte is read again until the busy bit clears. While the device is still busy, status reads are spaced by a programmable number of idle cycles. Programs are cut into pieces that stay inside one 256-byte page, and each piece gets its own write enable. The bytes to program come from a valid/ready stream and are passed straight through to the engine. Requests that make no sense are answered at once with an error flag, and no command is sent for them.

Top module: `flash_op_seq`

## Requirements
- R1: Before the first write enable of a request, status reads (opcode 0x05, address 0, length 1) repeat until bit 0 of the returned byte is 0. Every modifying command (0x01, 0x02, 0x20, 0x52, 0xD8, 0xC7) comes right after a write enable (0x06, address 0, length 0), and the device is never busy when one is issued.
- R2: When a status read returns bit 0 set, at least POLL_GAP idle cycles pass before the next status read starts. These are counted from the cycle the sequencer sees the completion pulse.
- R3: After each modifying command, status reads (0x05) repeat until bit 0 is 0. Only then does the next write enable start, or `done` rise.
- R4: Kind 4 (program) is issued as page program commands (0x02). Each chunk is min(remaining, 256 - address mod 256) bytes long, at increasing addresses, and has its own write enable. The stream bytes reach the engine in order and none is dropped.
- R5: Kind 0 issues sector erase 0x20 at the low 24 address bits, rounded down to a multiple of 4096.
- R6: Kind 1 issues 0x52 at the low 24 address bits rounded down to 32 KB. Kind 2 issues 0xD8 at the low 24 bits rounded down to 64 KB.
- R7: Kind 3 issues chip erase 0xC7 with address 0, whatever address was supplied.
- R8: Kind 5 reads the low byte (0x05) and the high byte (0x35) of the status, then sends write enable, then sends 0x01 with length 2: low byte first, then high byte. The block-protect field (status bits 6:2), the mode field (bits 8:7) and the quad bit (bit 9) are replaced. Bits 15:10 are written back as read.
- R9: A program of length 0, a program whose address plus length exceeds 0x800000, and kind codes 6 or 7 raise `done` with `err` set in the cycle after acceptance. No command is issued for them.
- R10: `req_ready` is high only when idle. `busy` is high from acceptance until `done`. `done` is a one-cycle pulse, and `eng_start` is a one-cycle pulse per command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_kind | input | 3 | Operation code 0..5 (see requirements) |
| req_addr | input | 32 | Byte address |
| req_len | input | 16 | Program length in bytes |
| req_prot | input | 5 | New block-protect field |
| req_mode | input | 2 | New protect-mode field |
| req_quad | input | 1 | New quad-enable bit |
| in_data | input | 8 | Program byte stream data |
| in_valid | input | 1 | Program byte present |
| in_ready | output | 1 | Program byte taken |
| done | output | 1 | Request finished (pulse) |
| err | output | 1 | Request rejected, valid with done |
| busy | output | 1 | Request in progress |
| eng_start | output | 1 | Start one engine command |
| eng_op | output | 8 | Command opcode |
| eng_addr | output | 24 | Command address |
| eng_len | output | 9 | Data byte count of the command |
| eng_wdata | output | 8 | Byte sent to the engine |
| eng_wvalid | output | 1 | Byte to engine valid |
| eng_wready | input | 1 | Engine takes the byte |
| eng_done | input | 1 | Engine finished the command (pulse) |
| eng_rdata | input | 8 | Byte read by the command, valid with eng_done |

## Verification
The assertions assume that the engine raises `eng_done` exactly once for each `eng_start`, and never while idle. They also assume that the engine takes exactly `eng_len` data bytes between the two. The bench engine model obeys this. It holds its completion pulse until every byte has been counted, then adds a fixed latency. It keeps the device busy for a set number of status reads after each modifying command, and also for several reads straight after reset, so both the first and the second polling loops spin. The program stream stalls every third cycle, and every request is issued only while `req_ready` is high.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam logic [7:0] OP_STAT_LO  = 8'h05;
  localparam logic [7:0] OP_STAT_HI  = 8'h35;
  localparam logic [7:0] OP_WR_EN    = 8'h06;
  localparam logic [7:0] OP_STAT_WR  = 8'h01;
  localparam logic [7:0] OP_PAGE_PRG = 8'h02;
  localparam logic [7:0] OP_ERS_SEC  = 8'h20;
  localparam logic [7:0] OP_ERS_32K  = 8'h52;
  localparam logic [7:0] OP_ERS_64K  = 8'hD8;
  localparam logic [7:0] OP_ERS_ALL  = 8'hC7;

  localparam logic [2:0] KIND_SECTOR = 3'd0;
  localparam logic [2:0] KIND_BLK32  = 3'd1;
  localparam logic [2:0] KIND_BLK64  = 3'd2;
  localparam logic [2:0] KIND_CHIP   = 3'd3;
  localparam logic [2:0] KIND_PROG   = 3'd4;
  localparam logic [2:0] KIND_STATUS = 3'd5;

  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_WAIT, S_GAP, S_DONE
  } seq_state_t;

  typedef enum logic [2:0] {
    P_PREPOLL, P_RDLO, P_RDHI, P_WEN, P_OP, P_POSTPOLL
  } seq_step_t;

endpackage

// File: rtl/flash_seq_align.sv
module flash_seq_align
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int IN_W   = 32,
  parameter int SEC_B  = 12,
  parameter int B32_B  = 15,
  parameter int B64_B  = 16
) (
  input  logic [2:0]        kind,
  input  logic [IN_W-1:0]   raw_addr,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_code
);

  logic [ADDR_W-1:0] masked;
  assign masked = raw_addr[ADDR_W-1:0];

  always_comb begin
    op_addr = masked;
    op_code = OP_PAGE_PRG;
    case (kind)
      KIND_SECTOR: begin
        op_addr = {masked[ADDR_W-1:SEC_B], {SEC_B{1'b0}}};
        op_code = OP_ERS_SEC;
      end
      KIND_BLK32: begin
        op_addr = {masked[ADDR_W-1:B32_B], {B32_B{1'b0}}};
        op_code = OP_ERS_32K;
      end
      KIND_BLK64: begin
        op_addr = {masked[ADDR_W-1:B64_B], {B64_B{1'b0}}};
        op_code = OP_ERS_64K;
      end
      KIND_CHIP: begin
        op_addr = '0;
        op_code = OP_ERS_ALL;
      end
      KIND_STATUS: begin
        op_addr = '0;
        op_code = OP_STAT_WR;
      end
      default: begin
        op_addr = masked;
        op_code = OP_PAGE_PRG;
      end
    endcase
  end

endmodule

// File: rtl/flash_seq_chunk.sv
module flash_seq_chunk #(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 256
) (
  input  logic [ADDR_W-1:0]                 cur_addr,
  input  logic [LEN_W-1:0]                  remain,
  output logic [$clog2(PAGE_BYTES):0]       chunk
);

  localparam int PB = $clog2(PAGE_BYTES);
  localparam int CW = PB + 1;

  logic [CW-1:0] room;

  always_comb begin
    room  = CW'(PAGE_BYTES) - {1'b0, cur_addr[PB-1:0]};
    chunk = (remain < LEN_W'(room)) ? CW'(remain) : room;
  end

endmodule

// File: rtl/flash_seq_gap.sv
module flash_seq_gap #(
  parameter int POLL_GAP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);

  localparam int LIM = (POLL_GAP > 0) ? POLL_GAP : 1;
  localparam int CW  = $clog2(LIM + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign expired = run && (cnt_q == CW'(LIM - 1));

  always_comb begin
    cnt_d = run ? (cnt_q + 1'b1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 256,
  parameter int MEM_BYTES  = 32'h0080_0000,
  parameter int POLL_GAP   = 4,
  parameter int ENG_LEN_W  = $clog2(PAGE_BYTES) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [2:0]           req_kind,
  input  logic [31:0]          req_addr,
  input  logic [LEN_W-1:0]     req_len,
  input  logic [4:0]           req_prot,
  input  logic [1:0]           req_mode,
  input  logic                 req_quad,
  input  logic [7:0]           in_data,
  input  logic                 in_valid,
  output logic                 in_ready,
  output logic                 done,
  output logic                 err,
  output logic                 busy,
  output logic                 eng_start,
  output logic [7:0]           eng_op,
  output logic [ADDR_W-1:0]    eng_addr,
  output logic [ENG_LEN_W-1:0] eng_len,
  output logic [7:0]           eng_wdata,
  output logic                 eng_wvalid,
  input  logic                 eng_wready,
  input  logic                 eng_done,
  input  logic [7:0]           eng_rdata
);

  localparam int CW = $clog2(PAGE_BYTES) + 1;
  localparam int PB = $clog2(PAGE_BYTES);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  seq_state_t        state_q, state_d;
  seq_step_t         step_q, step_d;
  logic [2:0]        kind_q, kind_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  remain_q, remain_d;
  logic [7:0]        op_q, op_d;
  logic [7:0]        lo_q, lo_d, hi_q, hi_d;
  logic [4:0]        prot_q, prot_d;
  logic [1:0]        mode_q, mode_d;
  logic              quad_q, quad_d;
  logic              err_q, err_d;
  logic [1:0]        widx_q, widx_d;

  logic [ADDR_W-1:0] al_addr;
  logic [7:0]        al_op;
  logic [CW-1:0]     chunk;
  logic              gap_run, gap_expired;
  logic              req_bad, accept;
  logic [32:0]       end_sum;
  logic              prog_xfer, stat_xfer, wr_fire;
  logic [7:0]        new_lo, new_hi;

  flash_seq_align #(.ADDR_W(ADDR_W), .IN_W(32)) u_align (
    .kind(req_kind), .raw_addr(req_addr), .op_addr(al_addr), .op_code(al_op)
  );

  flash_seq_chunk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)) u_chunk (
    .cur_addr(addr_q), .remain(remain_q), .chunk(chunk)
  );

  assign gap_run = (state_q == S_GAP);
  flash_seq_gap #(.POLL_GAP(POLL_GAP)) u_gap (
    .clk(clk), .rst_n(rst_sync_n), .run(gap_run), .expired(gap_expired)
  );

  // request screening
  assign end_sum = {1'b0, req_addr} + 33'(req_len);
  always_comb begin
    req_bad = 1'b0;
    if (req_kind > KIND_STATUS) req_bad = 1'b1;
    else if (req_kind == KIND_PROG)
      req_bad = (req_len == '0) || (end_sum > 33'(MEM_BYTES));
  end

  assign req_ready = (state_q == S_IDLE);
  assign accept    = req_ready && req_valid;
  assign busy      = (state_q != S_IDLE);
  assign done      = (state_q == S_DONE);
  assign err       = err_q;

  // command presented to the engine
  assign eng_start = (state_q == S_ISSUE);
  always_comb begin
    eng_op   = OP_STAT_LO;
    eng_addr = '0;
    eng_len  = ENG_LEN_W'(1);
    case (step_q)
      P_RDHI: eng_op = OP_STAT_HI;
      P_WEN: begin
        eng_op  = OP_WR_EN;
        eng_len = '0;
      end
      P_OP: begin
        eng_op   = op_q;
        eng_addr = addr_q;
        if (kind_q == KIND_PROG)        eng_len = ENG_LEN_W'(chunk);
        else if (kind_q == KIND_STATUS) eng_len = ENG_LEN_W'(2);
        else                            eng_len = '0;
      end
      default: ;
    endcase
  end

  // data toward the engine
  assign new_lo    = {mode_q[0], prot_q, lo_q[1:0]};
  assign new_hi    = {hi_q[7:2], quad_q, mode_q[1]};
  assign prog_xfer = (state_q == S_WAIT) && (step_q == P_OP) && (kind_q == KIND_PROG);
  assign stat_xfer = (state_q == S_WAIT) && (step_q == P_OP) && (kind_q == KIND_STATUS);
  assign in_ready  = prog_xfer && eng_wready;
  assign wr_fire   = stat_xfer && eng_wvalid && eng_wready;
  always_comb begin
    eng_wvalid = 1'b0;
    eng_wdata  = 8'h00;
    if (prog_xfer) begin
      eng_wvalid = in_valid;
      eng_wdata  = in_data;
    end else if (stat_xfer) begin
      eng_wvalid = (widx_q < 2'd2);
      eng_wdata  = (widx_q == 2'd0) ? new_lo : new_hi;
    end
  end

  // next state
  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    kind_d   = kind_q;
    addr_d   = addr_q;
    remain_d = remain_q;
    op_d     = op_q;
    lo_d     = lo_q;
    hi_d     = hi_q;
    prot_d   = prot_q;
    mode_d   = mode_q;
    quad_d   = quad_q;
    err_d    = err_q;
    widx_d   = widx_q;
    case (state_q)
      S_IDLE: if (req_valid) begin
        kind_d   = req_kind;
        addr_d   = al_addr;
        op_d     = al_op;
        remain_d = req_len;
        prot_d   = req_prot;
        mode_d   = req_mode;
        quad_d   = req_quad;
        widx_d   = '0;
        step_d   = P_PREPOLL;
        err_d    = req_bad;
        state_d  = req_bad ? S_DONE : S_ISSUE;
      end
      S_ISSUE: state_d = S_WAIT;
      S_WAIT: begin
        if (wr_fire) widx_d = widx_q + 2'd1;
        if (eng_done) begin
          state_d = S_ISSUE;
          case (step_q)
            P_PREPOLL:
              if (eng_rdata[0]) state_d = S_GAP;
              else step_d = (kind_q == KIND_STATUS) ? P_RDLO : P_WEN;
            P_RDLO: begin
              lo_d   = eng_rdata;
              step_d = P_RDHI;
            end
            P_RDHI: begin
              hi_d   = eng_rdata;
              step_d = P_WEN;
            end
            P_WEN: step_d = P_OP;
            P_OP: begin
              step_d = P_POSTPOLL;
              if (kind_q == KIND_PROG) begin
                addr_d   = addr_q + ADDR_W'(chunk);
                remain_d = remain_q - LEN_W'(chunk);
              end
            end
            P_POSTPOLL:
              if (eng_rdata[0]) state_d = S_GAP;
              else if ((kind_q == KIND_PROG) && (remain_q != '0)) step_d = P_WEN;
              else state_d = S_DONE;
            default: state_d = S_DONE;
          endcase
        end
      end
      S_GAP:  if (gap_expired) state_d = S_ISSUE;
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q  <= S_IDLE;
      step_q   <= P_PREPOLL;
      kind_q   <= '0;
      addr_q   <= '0;
      remain_q <= '0;
      op_q     <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      prot_q   <= '0;
      mode_q   <= '0;
      quad_q   <= 1'b0;
      err_q    <= 1'b0;
      widx_q   <= '0;
    end else begin
      state_q  <= state_d;
      step_q   <= step_d;
      kind_q   <= kind_d;
      addr_q   <= addr_d;
      remain_q <= remain_d;
      op_q     <= op_d;
      lo_q     <= lo_d;
      hi_q     <= hi_d;
      prot_q   <= prot_d;
      mode_q   <= mode_d;
      quad_q   <= quad_d;
      err_q    <= err_d;
      widx_q   <= widx_d;
    end
  end

  // assertion support: write enable seen since last modifying command
  logic is_mod_op, wen_armed_q;
  assign is_mod_op = (eng_op == OP_STAT_WR) || (eng_op == OP_PAGE_PRG) ||
                     (eng_op == OP_ERS_SEC) || (eng_op == OP_ERS_32K) ||
                     (eng_op == OP_ERS_64K) || (eng_op == OP_ERS_ALL);
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)                           wen_armed_q <= 1'b0;
    else if (eng_start && eng_op == OP_WR_EN)  wen_armed_q <= 1'b1;
    else if (eng_start && is_mod_op)           wen_armed_q <= 1'b0;
  end

  AST_WEN_FIRST: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (eng_start && is_mod_op) |-> wen_armed_q); // R1
  AST_PAGE_BOUND: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (eng_start && eng_op == OP_PAGE_PRG) |->
      (eng_len != '0) && ((32'(eng_addr[PB-1:0]) + 32'(eng_len)) <= PAGE_BYTES)); // R4
  AST_SECTOR_ALIGN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (eng_start && eng_op == OP_ERS_SEC) |-> (eng_addr[11:0] == '0)); // R5
  AST_BLOCK_ALIGN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (eng_start && (eng_op == OP_ERS_32K || eng_op == OP_ERS_64K)) |->
      (eng_addr[14:0] == '0) && (eng_op == OP_ERS_32K || eng_addr[15] == 1'b0)); // R6
  AST_CHIP_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (eng_start && eng_op == OP_ERS_ALL) |-> (eng_addr == '0)); // R7
  AST_STATUS_LEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (eng_start && eng_op == OP_STAT_WR) |-> (eng_len == ENG_LEN_W'(2))); // R8
  AST_REJECT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (accept && req_bad) |=> (done && err && !eng_start)); // R9
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    eng_start |=> !eng_start); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> (!done && req_ready)); // R10

endmodule

// File: tb/flash_op_seq_test.sv
module flash_op_seq_test;

  localparam int POLL_GAP = 3;
  localparam int LAT      = 2;
  localparam int WIPN     = 2;
  localparam int BOOT_WIP = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_kind = '0;
  logic [31:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic [4:0]  req_prot = '0;
  logic [1:0]  req_mode = '0;
  logic        req_quad = 1'b0;
  logic [7:0]  in_data;
  logic        in_valid;
  logic        in_ready;
  logic        done, err, busy;
  logic        eng_start;
  logic [7:0]  eng_op;
  logic [23:0] eng_addr;
  logic [8:0]  eng_len;
  logic [7:0]  eng_wdata;
  logic        eng_wvalid;
  logic        eng_wready;
  logic        eng_done;
  logic [7:0]  eng_rdata;

  always #5 clk = ~clk;

  flash_op_seq #(.POLL_GAP(POLL_GAP)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_addr(req_addr), .req_len(req_len), .req_prot(req_prot),
    .req_mode(req_mode), .req_quad(req_quad),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .done(done), .err(err), .busy(busy),
    .eng_start(eng_start), .eng_op(eng_op), .eng_addr(eng_addr), .eng_len(eng_len),
    .eng_wdata(eng_wdata), .eng_wvalid(eng_wvalid), .eng_wready(eng_wready),
    .eng_done(eng_done), .eng_rdata(eng_rdata)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 7) + 3);
  endfunction

  // expected command list
  typedef struct { int op; int addr; int len; string tag; } exp_t;
  exp_t expq[$];

  task automatic push(input int op, input int addr, input int len, input string tag);
    exp_t e;
    e.op = op; e.addr = addr; e.len = len; e.tag = tag;
    expq.push_back(e);
  endtask

  // behavioural engine + device model
  int          cyc;
  logic        eb_busy;
  int          eb_left, eb_lat, eb_bidx;
  logic [7:0]  eb_op, prev_op, wlo, whi;
  logic [15:0] stat;
  int          wip_cnt;
  logic        wel, last_wip;
  int          last_poll_done;
  int          rx_idx, src_idx;

  assign eng_wready = eb_busy && (eb_left > 0);
  assign in_valid   = (cyc % 3) != 0;
  assign in_data    = pat(src_idx);

  function automatic bit mod_op(input logic [7:0] op);
    return op == 8'h01 || op == 8'h02 || op == 8'h20 || op == 8'h52 ||
           op == 8'hD8 || op == 8'hC7;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc <= 0; eb_busy <= 1'b0; eb_left <= 0; eb_lat <= 0; eb_bidx <= 0;
      eb_op <= 8'h00; prev_op <= 8'h00; wlo <= 8'h00; whi <= 8'h00;
      stat <= 16'hB4A0; wip_cnt <= BOOT_WIP; wel <= 1'b0; last_wip <= 1'b0;
      last_poll_done <= 0; rx_idx <= 0; src_idx <= 0;
      eng_done <= 1'b0; eng_rdata <= 8'h00;
    end else begin
      cyc <= cyc + 1;
      eng_done <= 1'b0;
      if (in_valid && in_ready) src_idx <= src_idx + 1;
      if (eng_start) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R9 unexpected command", {eng_op, eng_addr, 7'd0, eng_len}, 0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          chk(eng_op == e.op[7:0] && eng_addr == e.addr[23:0] && eng_len == e.len[8:0],
              e.tag, {eng_op, eng_addr, 7'd0, eng_len},
              {e.op[7:0], e.addr[23:0], 7'd0, e.len[8:0]});
        end
        if (eng_op == 8'h05 && prev_op == 8'h05 && last_wip)
          chk(cyc - last_poll_done >= POLL_GAP + 1, "R2 poll spacing",
              cyc - last_poll_done, POLL_GAP + 1);
        if (mod_op(eng_op))
          chk(wel && wip_cnt == 0, "R1 write enabled and device idle",
              {wel, 8'(wip_cnt)}, 9'h100);
        eb_busy <= 1'b1; eb_lat <= LAT; eb_op <= eng_op; eb_bidx <= 0;
        eb_left <= (eng_op == 8'h02 || eng_op == 8'h01) ? int'(eng_len) : 0;
        prev_op <= eng_op;
      end else if (eb_busy) begin
        if (eng_wvalid && eng_wready) begin
          if (eb_op == 8'h02) begin
            chk(eng_wdata == pat(rx_idx), "R4 program byte", eng_wdata, pat(rx_idx));
            rx_idx <= rx_idx + 1;
          end else if (eb_bidx == 0) wlo <= eng_wdata;
          else                       whi <= eng_wdata;
          eb_bidx <= eb_bidx + 1;
          eb_left <= eb_left - 1;
        end else if (eb_left == 0) begin
          if (eb_lat > 0) eb_lat <= eb_lat - 1;
          else begin
            eb_busy  <= 1'b0;
            eng_done <= 1'b1;
            case (eb_op)
              8'h05: begin
                eng_rdata <= {stat[7:2], wel, wip_cnt > 0};
                last_wip  <= wip_cnt > 0;
                last_poll_done <= cyc + 1;
                if (wip_cnt > 0) wip_cnt <= wip_cnt - 1;
              end
              8'h35: eng_rdata <= stat[15:8];
              8'h06: wel <= 1'b1;
              8'h01: begin
                stat[15:2] <= {whi, wlo[7:2]};
                wip_cnt <= WIPN; wel <= 1'b0;
              end
              default: begin
                wip_cnt <= WIPN; wel <= 1'b0;
              end
            endcase
          end
        end
      end
    end
  end

  // builds the expected command list and runs one request
  task automatic run_req(input logic [2:0] kind, input logic [31:0] addr,
                         input logic [15:0] len, input bit bad, input string tag);
    int guard;
    if (!bad) begin
      for (int i = 0; i <= wip_cnt; i++) push(8'h05, 0, 1, "R1 pre-poll");
      if (kind == 3'd5) begin
        push(8'h05, 0, 1, "R8 read low");
        push(8'h35, 0, 1, "R8 read high");
      end
      if (kind == 3'd4) begin
        int a, r, c;
        a = int'(addr); r = int'(len);
        while (r > 0) begin
          c = 256 - (a % 256);
          if (r < c) c = r;
          push(8'h06, 0, 0, "R4 chunk write enable");
          push(8'h02, a, c, "R4 chunk");
          for (int i = 0; i <= WIPN; i++) push(8'h05, 0, 1, "R3 post-poll");
          a += c; r -= c;
        end
      end else begin
        int oa, op;
        case (kind)
          3'd0: begin op = 8'h20; oa = int'(addr[23:0]) & 32'hFFF000; end
          3'd1: begin op = 8'h52; oa = int'(addr[23:0]) & 32'hFF8000; end
          3'd2: begin op = 8'hD8; oa = int'(addr[23:0]) & 32'hFF0000; end
          3'd3: begin op = 8'hC7; oa = 0; end
          default: begin op = 8'h01; oa = 0; end
        endcase
        push(8'h06, 0, 0, "R1 write enable");
        push(op, oa, (kind == 3'd5) ? 2 : 0, tag);
        for (int i = 0; i <= WIPN; i++) push(8'h05, 0, 1, "R3 post-poll");
      end
    end
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready when idle", req_ready, 1);
    req_valid = 1'b1; req_kind = kind; req_addr = addr; req_len = len;
    @(negedge clk);
    req_valid = 1'b0;
    if (bad) begin
      chk(done && err, {tag, " R9 immediate error"}, {done, err}, 2'b11);
    end else begin
      chk(busy && !done, "R10 busy after accept", {busy, done}, 2'b10);
      guard = 0;
      while (!done && guard < 20000) begin
        @(negedge clk);
        guard++;
      end
      chk(done && !err, {tag, " R10 done without error"}, {done, err}, 2'b10);
      chk(wip_cnt == 0, "R3 device idle at done", wip_cnt, 0);
    end
    chk(expq.size() == 0, {tag, " R3 full sequence before done"}, expq.size(), 0);
    expq.delete();
    @(negedge clk);
    chk(!done && req_ready, "R10 done is a pulse", {done, req_ready}, 2'b01);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R10 actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [15:0] old, want;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !eng_start && req_ready, "R10 reset state",
        {busy, done, eng_start, req_ready}, 4'b0001);

    run_req(3'd0, 32'h0AB1_2345, 16'd0, 1'b0, "R5 sector erase");
    run_req(3'd1, 32'h0013_7FFF, 16'd0, 1'b0, "R6 32K erase");
    run_req(3'd2, 32'h0013_7FFF, 16'd0, 1'b0, "R6 64K erase");
    run_req(3'd2, 32'h00AB_CDEF, 16'd0, 1'b0, "R6 64K erase high");
    run_req(3'd3, 32'h0012_3456, 16'd0, 1'b0, "R7 chip erase");
    run_req(3'd4, 32'h0000_00F0, 16'd300, 1'b0, "R4 three chunks");
    run_req(3'd4, 32'h0000_1000, 16'd256, 1'b0, "R4 whole page");
    run_req(3'd4, 32'h007F_FFFE, 16'd2, 1'b0, "R4 last bytes");
    run_req(3'd4, 32'h0000_0100, 16'd0, 1'b1, "R9 zero length");
    run_req(3'd4, 32'h007F_FFFF, 16'd2, 1'b1, "R9 past end");
    run_req(3'd4, 32'h0100_0000, 16'd1, 1'b1, "R9 high address");
    run_req(3'd6, 32'h0000_0000, 16'd0, 1'b1, "R9 bad kind");

    old = stat;
    req_prot = 5'h13; req_mode = 2'b10; req_quad = 1'b1;
    run_req(3'd5, 32'h0000_0000, 16'd0, 1'b0, "R8 status write");
    want = (old & ~16'h03FC) | (16'(1) << 9) | (16'(2) << 7) | (16'h13 << 2);
    chk(stat[15:2] == want[15:2], "R8 status fields", stat, want);

    summary();
  end

endmodule